// File: doc/BRIEF.md
# Multiplexed ADC Serial Sequencer

This controller drives an eight-channel successive-approximation converter that sits behind a four-wire serial port. A transaction begins when `start` is pulsed while the controller is idle. The controller pulses the convert strobe and waits for the converter's ready line to come back high. It then pulls the read strobe low and runs sixteen serial clocks. During those clocks it sends the next eight-bit configuration word out on the data-out line and collects the sixteen-bit result on the data-in line.

The converter answers one transfer late. The result collected in a transfer was produced by the configuration word sent in the transfer before it. The controller therefore keeps the channel of the last word it sent and attaches that channel to each result it delivers. It has no earlier word to point to after reset, and none after a word that put the converter to sleep. In both cases the next result is withheld. The channel can come straight from the request input. It can also come from a round-robin walk over a channel mask. A converter that never reports ready is cut off by a timeout.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held and right after it, `adc_rd_n` is 1, `adc_sck`, `adc_convst`, `res_valid` and `tmo_err` are 0, and `seq_idle` is 1.
- R2: Each transfer sends the word {channel[2:0], 3'b100, nap, sleep} on `adc_sdi`, most significant bit first, one bit per rising `adc_sck` edge over the first eight edges. Here nap is `pwr_req[1]` and sleep is `pwr_req[0]`.
- R3: A transaction pulses `adc_convst` while `adc_rd_n` is high. `adc_rd_n` falls only after `adc_ready` has been seen high. `adc_sck` rises only while `adc_rd_n` is low, and a transfer has exactly sixteen rising edges.
- R4: `adc_sdo` is sampled on each rising `adc_sck` edge, most significant bit first. In `res_data`, the lowest 16-RES_BITS bits are forced to zero.
- R5: `res_ch` carries the channel of the configuration word sent in the transfer before the one that collected the data.
- R6: The first transfer after reset produces no `res_valid` pulse.
- R7: After a word with the sleep bit set, the following transfer produces no `res_valid`. A word with only the nap bit set does not suppress the next result.
- R8: While `rr_en` is 1 and `rr_mask` is nonzero, the channel is the first mask bit after the last round-robin channel, wrapping from 7 to 0. After reset the walk starts at channel 0. When `rr_en` is 0, `req_ch` is used.
- R9: If `adc_ready` stays low for BUSY_TMO cycles, `tmo_err` pulses for one cycle and the controller returns to idle without a transfer. The channel of the last word sent is unchanged.
- R10: `adc_sdi` changes only on falling `adc_sck` edges, so it is stable at every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one transaction when idle |
| req_ch | input | 3 | Directly requested channel |
| rr_en | input | 1 | Select the round-robin walk |
| rr_mask | input | 8 | Channels taking part in the walk |
| pwr_req | input | 2 | {nap, sleep} bits for the word |
| seq_idle | output | 1 | Controller ready for `start` |
| tmo_err | output | 1 | One-cycle ready-timeout pulse |
| adc_sck | output | 1 | Serial clock |
| adc_sdi | output | 1 | Configuration bit to converter |
| adc_convst | output | 1 | Convert strobe |
| adc_rd_n | output | 1 | Active-low read enable |
| adc_ready | input | 1 | Converter not busy (low while converting) |
| adc_sdo | input | 1 | Result bit from converter |
| res_valid | output | 1 | Result pulse |
| res_data | output | 16 | Masked two's-complement result |
| res_ch | output | 3 | Channel that produced the result |

## Verification
The bench builds the controller with CLK_DIV=2, RES_BITS=14 and BUSY_TMO=40. A divider of 2 keeps each transfer near seventy cycles, so twelve table rows fit easily alongside the directed cases. A 14-bit width makes the masking visible: the converter model always returns low bits 0111, and the controller must deliver 0100. A 40-cycle timeout lets the stuck-ready case expire quickly while staying well above the model's ten-cycle conversion.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CLK_DIV  = 4,
  parameter int RES_BITS = 16,
  parameter int BUSY_TMO = 1000,
  parameter logic [2:0] CFG_MID = 3'b100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  req_ch,
  input  logic        rr_en,
  input  logic [7:0]  rr_mask,
  input  logic [1:0]  pwr_req,
  output logic        seq_idle,
  output logic        tmo_err,
  output logic        adc_sck,
  output logic        adc_sdi,
  output logic        adc_convst,
  output logic        adc_rd_n,
  input  logic        adc_ready,
  input  logic        adc_sdo,
  output logic        res_valid,
  output logic [15:0] res_data,
  output logic [2:0]  res_ch
);

  localparam int NCH   = 8;
  localparam int CHW   = 3;
  localparam int FRAME = 16;
  localparam int DW    = $clog2(CLK_DIV + 1);
  localparam int TW    = $clog2(BUSY_TMO + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(BUSY_TMO - 1);
  localparam logic [FRAME-1:0] KEEP = {FRAME{1'b1}} << (FRAME - RES_BITS);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_WAIT, S_SHIFT} state_t;
  state_t state;

  logic [DW-1:0]    div_cnt;
  logic [TW-1:0]    tmo_cnt;
  logic [3:0]       bit_cnt;
  logic [FRAME-1:0] tx, rx;
  logic [CHW-1:0]   cur_ch, prev_ch, rr_last, rr_pick, ch_sel;
  logic             cur_slp, tag_ok, rr_use;

  wire div_end = (div_cnt == DIV_LAST);

  always_comb begin
    rr_pick = rr_last;
    for (int i = NCH; i >= 1; i--)
      if (rr_mask[(int'(rr_last) + i) % NCH]) rr_pick = CHW'((int'(rr_last) + i) % NCH);
  end

  assign rr_use   = rr_en && (|rr_mask);
  assign ch_sel   = rr_use ? rr_pick : req_ch;
  assign seq_idle = (state == S_IDLE);
  assign adc_sdi  = tx[FRAME-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      div_cnt    <= '0;
      tmo_cnt    <= '0;
      bit_cnt    <= '0;
      tx         <= '0;
      rx         <= '0;
      cur_ch     <= '0;
      prev_ch    <= '0;
      cur_slp    <= 1'b0;
      tag_ok     <= 1'b0;
      rr_last    <= CHW'(NCH - 1);
      adc_sck    <= 1'b0;
      adc_convst <= 1'b0;
      adc_rd_n   <= 1'b1;
      tmo_err    <= 1'b0;
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_ch     <= '0;
    end else begin
      res_valid <= 1'b0;
      tmo_err   <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cur_ch     <= ch_sel;
          cur_slp    <= pwr_req[0];
          tx         <= {ch_sel, CFG_MID, pwr_req, 8'h00};
          if (rr_use) rr_last <= ch_sel;
          adc_convst <= 1'b1;
          div_cnt    <= '0;
          state      <= S_CONV;
        end
        S_CONV: begin
          if (div_end) begin
            adc_convst <= 1'b0;
            tmo_cnt    <= '0;
            state      <= S_WAIT;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (adc_ready) begin
            adc_rd_n <= 1'b0;
            div_cnt  <= '0;
            bit_cnt  <= '0;
            state    <= S_SHIFT;
          end else if (tmo_cnt == TMO_LAST) begin
            tmo_err <= 1'b1;
            state   <= S_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        S_SHIFT: begin
          if (!div_end) begin
            div_cnt <= div_cnt + 1'b1;
          end else begin
            div_cnt <= '0;
            if (!adc_sck) begin
              adc_sck <= 1'b1;
              rx      <= {rx[FRAME-2:0], adc_sdo};
            end else begin
              adc_sck <= 1'b0;
              tx      <= {tx[FRAME-2:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 4'd15) begin
                adc_rd_n  <= 1'b1;
                state     <= S_IDLE;
                res_valid <= tag_ok;
                res_data  <= rx & KEEP;
                res_ch    <= prev_ch;
                prev_ch   <= cur_ch;
                tag_ok    <= ~cur_slp;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_read_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rd_n) |-> $past(adc_ready));
  assert_sck_inside_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sck) |-> !adc_rd_n);
  assert_convst_outside_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_convst |-> adc_rd_n);
  assert_sdi_steady_at_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sck) |-> $stable(adc_sdi));
  assert_timeout_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (adc_rd_n && !res_valid && seq_idle));
  assert_result_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_data & ~KEEP) == '0));

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, rr_en = 1'b0;
  logic [2:0] req_ch = '0;
  logic [7:0] rr_mask = 8'b1010_0100;
  logic [1:0] pwr_req = '0;
  logic seq_idle, tmo_err, adc_sck, adc_sdi, adc_convst, adc_rd_n, res_valid;
  logic [15:0] res_data;
  logic [2:0] res_ch;
  logic adc_ready = 1'b1, adc_sdo = 1'b0;

  adc_seq_ctrl #(.CLK_DIV(2), .RES_BITS(14), .BUSY_TMO(40)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_ch(req_ch), .rr_en(rr_en),
    .rr_mask(rr_mask), .pwr_req(pwr_req), .seq_idle(seq_idle), .tmo_err(tmo_err),
    .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_convst(adc_convst), .adc_rd_n(adc_rd_n),
    .adc_ready(adc_ready), .adc_sdo(adc_sdo), .res_valid(res_valid),
    .res_data(res_data), .res_ch(res_ch));

  // converter model
  int mcnt = 0, seq = 0, icnt = 0, rises = 0;
  logic conv_seen = 1'b0, stuck = 1'b0, proto_bad = 1'b0;
  logic [15:0] raw = '0, osr = '0;
  logic [7:0] isr = '0, cap_word = '0;
  logic [2:0] pend_ch = '0;

  always @(posedge clk) begin
    if (adc_convst && !conv_seen) begin
      adc_ready <= 1'b0;
      mcnt <= 10;
      raw <= {pend_ch, 1'b1, 8'(seq), 4'b0111};
      seq <= seq + 1;
    end else if (!adc_ready && !stuck) begin
      if (mcnt <= 1) adc_ready <= 1'b1;
      else mcnt <= mcnt - 1;
    end
    conv_seen <= adc_convst;
  end
  always @(negedge adc_rd_n) begin
    if (!adc_ready) proto_bad = 1'b1;
    osr = raw; adc_sdo = osr[15]; icnt = 0; rises = 0;
  end
  always @(negedge adc_sck) if (!adc_rd_n) begin osr = osr << 1; adc_sdo = osr[15]; end
  always @(posedge adc_sck) begin
    if (adc_rd_n) proto_bad = 1'b1;
    rises++;
    if (icnt < 8) begin isr = {isr[6:0], adc_sdi}; icnt++; end
  end
  always @(posedge adc_rd_n) if (rst_n) begin
    if (rises != 16) proto_bad = 1'b1;
    cap_word = isr; pend_ch = isr[7:5];
  end

  // monitor
  logic got_v, got_t, got_rd;
  logic [15:0] got_d;
  logic [2:0] got_c;
  always @(negedge clk) begin
    if (res_valid) begin got_v = 1'b1; got_d = res_data; got_c = res_ch; end
    if (tmo_err) got_t = 1'b1;
    if (!adc_rd_n) got_rd = 1'b1;
  end

  int checks = 0, failures = 0, txn = 0;
  logic done = 1'b0;

  task automatic check(input logic ok, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_txn(input logic rr, input logic [2:0] ch, input logic [1:0] pw);
    int n;
    @(negedge clk);
    rr_en = rr; req_ch = ch; pwr_req = pw;
    got_v = 1'b0; got_t = 1'b0; got_rd = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!seq_idle && n < 5000) begin @(negedge clk); n++; end
    check(n < 5000, "R3 transaction completes", 16'(n), 16'd0);
    @(negedge clk);
    txn++;
  endtask

  // {rr, req_ch, pwr, exp_valid, exp_tag, exp_sent_ch}
  localparam logic [12:0] VEC [0:11] = '{
    13'b0_101_00_0_000_101,
    13'b0_010_00_1_101_010,
    13'b0_111_10_1_010_111,
    13'b0_001_00_1_111_001,
    13'b0_011_01_1_001_011,
    13'b0_100_00_0_000_100,
    13'b0_000_00_1_100_000,
    13'b1_000_00_1_000_010,
    13'b1_000_00_1_010_101,
    13'b1_000_00_1_101_111,
    13'b1_000_00_1_111_010,
    13'b0_110_00_1_010_110
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(adc_rd_n && !adc_sck && !adc_convst && !res_valid && !tmo_err && seq_idle,
          "R1 outputs during reset", {10'd0, adc_rd_n, adc_sck, adc_convst, res_valid, tmo_err, seq_idle}, 16'h0021);
    rst_n = 1'b1;
    @(negedge clk);
    check(adc_rd_n && !adc_sck && !adc_convst && seq_idle, "R1 outputs after reset",
          {12'd0, adc_rd_n, adc_sck, adc_convst, seq_idle}, 16'h0009);

    for (int i = 0; i < 12; i++) begin
      logic [12:0] v;
      int k;
      v = VEC[i];
      k = txn;
      run_txn(v[12], v[11:9], v[8:7]);
      check(cap_word == {v[2:0], 3'b100, v[8:7]}, "R2/R8 configuration word",
            {8'd0, cap_word}, {8'd0, v[2:0], 3'b100, v[8:7]});
      check(got_v == v[6], "R6/R7 result valid", {15'd0, got_v}, {15'd0, v[6]});
      if (v[6]) begin
        check(got_c == v[5:3], "R5 result channel", {13'd0, got_c}, {13'd0, v[5:3]});
        check(got_d == ({v[5:3], 1'b1, 8'(k), 4'b0111} & 16'hFFFC), "R4 result data",
              got_d, {v[5:3], 1'b1, 8'(k), 4'b0111} & 16'hFFFC);
      end
    end

    // R9: converter never reports ready
    stuck = 1'b1;
    run_txn(1'b0, 3'd3, 2'b00);
    check(got_t, "R9 timeout pulse", {15'd0, got_t}, 16'd1);
    check(!got_rd && !got_v, "R9 no transfer on timeout", {14'd0, got_rd, got_v}, 16'd0);
    stuck = 1'b0;
    repeat (30) @(negedge clk);
    begin
      int k;
      k = txn;
      run_txn(1'b0, 3'd1, 2'b00);
      check(got_v && got_c == 3'd6, "R9 tag kept across timeout", {12'd0, got_v, got_c}, 16'h000E);
      check(got_d == ({3'd6, 1'b1, 8'(k), 4'b0111} & 16'hFFFC), "R4 data after timeout",
            got_d, {3'd6, 1'b1, 8'(k), 4'b0111} & 16'hFFFC);
    end

    // R6: reset mid-stream drops the tag again
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(adc_rd_n && !adc_sck && !adc_convst && seq_idle, "R1 outputs on second reset",
          {12'd0, adc_rd_n, adc_sck, adc_convst, seq_idle}, 16'h0009);
    rst_n = 1'b1;
    run_txn(1'b0, 3'd2, 2'b00);
    check(!got_v, "R6 first result after reset suppressed", {15'd0, got_v}, 16'd0);
    run_txn(1'b1, 3'd0, 2'b00);
    check(cap_word == {3'd2, 3'b100, 2'b00}, "R8 walk restarts after reset",
          {8'd0, cap_word}, {8'd0, 3'd2, 3'b100, 2'b00});
    check(got_v && got_c == 3'd2, "R5 tag after reset", {12'd0, got_v, got_c}, 16'h000A);

    check(!proto_bad, "R3/R10 serial protocol order", {15'd0, proto_bad}, 16'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule